// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block brings up a set of supply regulators in a fixed order after a power-up request. The always-on primary rail comes on first and unconditionally. After a 5 ms settling wait the sequencer walks through six configurable slots. Each slot names a regulator to enable, or a GPIO reconfiguration, and gives the delay that comes before it. A seventh, restricted slot can only turn on the last rail, and it also flags that rail's reduced output-voltage setting.

When the slot walk is complete, two independent timers run from that point. Power-good is raised after 3 ms. The active-low system reset is released after a delay chosen by a code, in 10 ms steps from 10 ms to 110 ms. A shutdown request clears every output together at any point and returns the sequencer to idle. The time base is a millisecond tick divided down from the system clock by a parameter.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is held, and in idle, every rail enable, the GPIO strobe, the low-voltage flag and power-good are low, and the system reset output is low (asserted).
- R2: A power-up request sampled in idle sets rail enable bit 0 at the next clock edge, and no other output changes at that edge.
- R3: The first slot starts 5*TICK_DIV+1 cycles after rail 0 is enabled.
- R4: Each slot takes its 2-bit delay code: 0 means the slot is unused, 1 means 0 ms, 2 means 1 ms and 3 means 4 ms. A used slot acts D*TICK_DIV+1 cycles after it is entered. An unused slot takes one cycle and does nothing.
- R5: In the six main slots, a 3-bit rail field of 1 to 6 enables that rail. A field of 0 gives a one-cycle pulse on gpio_stb_o. A field of 7 has no effect.
- R6: The seventh slot uses x7_dly_i with the same encoding as R4. When it is used, it enables rail 7 and raises lowv_o. Rail 7 can be enabled in no other way.
- R7: Power-good rises 3*TICK_DIV+1 cycles after the edge at which the seventh slot completes.
- R8: The system reset is released (driven high) (min(code,10)+1)*10*TICK_DIV+1 cycles after that same edge. Power-good is always high while the reset is released.
- R9: A shutdown request sampled at any edge clears all outputs at that edge and returns the block to idle. It takes priority over a power-up request. A later power-up request restarts the whole sequence.
- R10: A power-up request outside idle is ignored. Rail enables never fall except through a shutdown request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req_i | input | 1 | Power-up request |
| off_req_i | input | 1 | Shutdown request |
| slot_rail_i | input | SLOTS*3 | Rail field per main slot, slot k at bits [3k+2:3k] |
| slot_dly_i | input | SLOTS*2 | Delay code per main slot, slot k at bits [2k+1:2k] |
| x7_dly_i | input | 2 | Delay code of the restricted seventh slot |
| rst_code_i | input | 4 | Reset-release delay code, 10 ms steps |
| rail_en_o | output | RAILS | Regulator enables, bit 0 is the primary rail |
| gpio_stb_o | output | 1 | One-cycle GPIO reconfiguration strobe |
| lowv_o | output | 1 | Reduced-voltage select for rail 7 |
| pwr_good_o | output | 1 | Power-good |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
A wrong slot index or a wrong millisecond count inside the block shows up as an enable edge or a GPIO pulse in the wrong cycle. It also changes the exact spacing between the last slot and the power-good and reset edges. The cycle-exact reference catches this in the cycle the edge should have come, and the rail set at the end also shows a skipped or doubled slot. A shutdown that does not clear all the state shows up one cycle after the request, as an output still high, or on restart as a sequence that no longer begins with rail 0 alone.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOOT,
    ST_SLOT,
    ST_POST,
    ST_DONE
  } seq_st_e;

  localparam int DLY_W = 2;

  // slot delay code to milliseconds; code 0 (unused) waits nothing
  function automatic logic [2:0] code_to_ms(input logic [DLY_W-1:0] code);
    case (code)
      2'd2:    code_to_ms = 3'd1;
      2'd3:    code_to_ms = 3'd4;
      default: code_to_ms = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int TICK_DIV = 1000,
  parameter int MS_W     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  output logic [MS_W-1:0] ms_o
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [MS_W-1:0]  MS_MAX   = {MS_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clr_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (pre_q == PRE_LAST) begin
      pre_d = '0;
      if (ms_q != MS_MAX) ms_d = ms_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  assign ms_o = ms_q;

  // R4
  ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (ms_q == $past(ms_q) || ms_q == $past(ms_q) + 1'b1));

endmodule

// File: rtl/pwrseq_slot_dec.sv
module pwrseq_slot_dec
  import pwrseq_pkg::*;
#(
  parameter int SLOTS  = 6,
  parameter int RAILS  = 8,
  parameter int IDX_W  = 3,
  parameter int RAIL_W = 3
) (
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [SLOTS*RAIL_W-1:0] slot_rail_i,
  input  logic [SLOTS*DLY_W-1:0]  slot_dly_i,
  input  logic [DLY_W-1:0]        x7_dly_i,
  output logic [2:0]              ms_o,
  output logic [RAILS-1:0]        set_o,
  output logic                    gpio_o,
  output logic                    low_o
);

  localparam logic [RAIL_W-1:0] XRAIL = RAIL_W'(RAILS - 1);

  logic [RAIL_W-1:0] rail_f [SLOTS];
  logic [DLY_W-1:0]  dly_f  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_field
    assign rail_f[g] = slot_rail_i[g*RAIL_W +: RAIL_W];
    assign dly_f[g]  = slot_dly_i[g*DLY_W +: DLY_W];
  end

  logic [DLY_W-1:0]  code;
  logic [RAIL_W-1:0] rsel;

  always_comb begin
    code   = x7_dly_i;
    rsel   = XRAIL;
    set_o  = '0;
    gpio_o = 1'b0;
    low_o  = 1'b0;
    if (int'(idx_i) < SLOTS) begin
      code = dly_f[int'(idx_i)];
      rsel = rail_f[int'(idx_i)];
      if (code != '0) begin
        if (rsel == '0)        gpio_o = 1'b1;
        else if (rsel != XRAIL) set_o = RAILS'(1) << rsel;
      end
    end else if (code != '0) begin
      set_o = RAILS'(1) << XRAIL;
      low_o = 1'b1;
    end
    ms_o = code_to_ms(code);
  end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int SLOTS       = 6,
  parameter int RAILS       = 8,
  parameter int BOOT_MS     = 5,
  parameter int PG_MS       = 3,
  parameter int RST_STEP_MS = 10,
  parameter int RST_CODES   = 11,
  parameter int CODE_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_req_i,
  input  logic                    off_req_i,
  input  logic [SLOTS*$clog2(RAILS)-1:0] slot_rail_i,
  input  logic [SLOTS*2-1:0]      slot_dly_i,
  input  logic [1:0]              x7_dly_i,
  input  logic [CODE_W-1:0]       rst_code_i,
  output logic [RAILS-1:0]        rail_en_o,
  output logic                    gpio_stb_o,
  output logic                    lowv_o,
  output logic                    pwr_good_o,
  output logic                    sys_rst_n_o
);

  localparam int RAIL_W = $clog2(RAILS);
  localparam int IDX_W  = $clog2(SLOTS + 1);
  localparam int MAX_MS = RST_STEP_MS * RST_CODES;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  seq_st_e           st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RAILS-1:0]  rail_q, rail_d;
  logic              gpio_q, gpio_d, low_q, low_d, pg_q, pg_d, nrst_q, nrst_d;
  logic              clr;
  logic [MS_W-1:0]   ms;
  logic [2:0]        dec_ms;
  logic [RAILS-1:0]  dec_set;
  logic              dec_gpio, dec_low;
  logic [MS_W-1:0]   rst_ms;

  pwrseq_tick #(.TICK_DIV(TICK_DIV), .MS_W(MS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ms_o(ms)
  );

  pwrseq_slot_dec #(.SLOTS(SLOTS), .RAILS(RAILS), .IDX_W(IDX_W), .RAIL_W(RAIL_W)) u_dec (
    .idx_i(idx_q), .slot_rail_i(slot_rail_i), .slot_dly_i(slot_dly_i),
    .x7_dly_i(x7_dly_i), .ms_o(dec_ms), .set_o(dec_set),
    .gpio_o(dec_gpio), .low_o(dec_low)
  );

  always_comb begin
    int unsigned c;
    c = (int'(rst_code_i) > RST_CODES - 1) ? RST_CODES - 1 : int'(rst_code_i);
    rst_ms = MS_W'((c + 1) * RST_STEP_MS);
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    rail_d = rail_q;
    gpio_d = 1'b0;
    low_d  = low_q;
    pg_d   = pg_q;
    nrst_d = nrst_q;
    clr    = 1'b0;
    if (off_req_i) begin
      st_d   = ST_IDLE;
      idx_d  = '0;
      rail_d = '0;
      low_d  = 1'b0;
      pg_d   = 1'b0;
      nrst_d = 1'b0;
      clr    = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          clr = 1'b1;
          if (pwr_req_i) begin
            st_d      = ST_BOOT;
            rail_d[0] = 1'b1;
          end
        end
        ST_BOOT: begin
          if (ms == MS_W'(BOOT_MS)) begin
            st_d  = ST_SLOT;
            idx_d = '0;
            clr   = 1'b1;
          end
        end
        ST_SLOT: begin
          if (ms == MS_W'(dec_ms)) begin
            rail_d = rail_q | dec_set;
            gpio_d = dec_gpio;
            low_d  = low_q | dec_low;
            clr    = 1'b1;
            if (idx_q == IDX_W'(SLOTS)) st_d = ST_POST;
            else idx_d = idx_q + 1'b1;
          end
        end
        ST_POST: begin
          if (ms == MS_W'(PG_MS)) pg_d = 1'b1;
          if (ms == rst_ms) begin
            nrst_d = 1'b1;
            st_d   = ST_DONE;
          end
        end
        ST_DONE: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      rail_q <= '0;
      gpio_q <= 1'b0;
      low_q  <= 1'b0;
      pg_q   <= 1'b0;
      nrst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rail_q <= rail_d;
      gpio_q <= gpio_d;
      low_q  <= low_d;
      pg_q   <= pg_d;
      nrst_q <= nrst_d;
    end
  end

  assign rail_en_o   = rail_q;
  assign gpio_stb_o  = gpio_q;
  assign lowv_o      = low_q;
  assign pwr_good_o  = pg_q;
  assign sys_rst_n_o = nrst_q;

  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_req_i |=> (rail_en_o == '0 && !pwr_good_o && !sys_rst_n_o && !gpio_stb_o && !lowv_o));

  // R10
  rail_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !off_req_i |=> (($past(rail_en_o) & ~rail_en_o) == '0));

  // R2
  primary_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en_o[0] |-> (rail_en_o == '0 && !pwr_good_o && !sys_rst_n_o));

  // R8
  rst_after_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n_o |-> pwr_good_o);

  // R6
  lowv_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowv_o |-> rail_en_o[RAILS-1]);

  // R7
  pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good_o) |-> (st_q == ST_POST || st_q == ST_DONE));

endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 4;
  localparam int SLOTS  = 6;
  localparam int RAILS  = 8;
  localparam int WD_LIM = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_req = 1'b0;
  logic off_req = 1'b0;
  logic [SLOTS*3-1:0] cfg_rail = '0;
  logic [SLOTS*2-1:0] cfg_dly = '0;
  logic [1:0] cfg_x7 = '0;
  logic [3:0] cfg_code = '0;
  logic [RAILS-1:0] rail_en;
  logic gpio_stb, lowv, pg, nrst;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_top #(.TICK_DIV(DIV), .SLOTS(SLOTS), .RAILS(RAILS)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_req_i(pwr_req), .off_req_i(off_req),
    .slot_rail_i(cfg_rail), .slot_dly_i(cfg_dly), .x7_dly_i(cfg_x7),
    .rst_code_i(cfg_code), .rail_en_o(rail_en), .gpio_stb_o(gpio_stb),
    .lowv_o(lowv), .pwr_good_o(pg), .sys_rst_n_o(nrst)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 boot, 2 slots, 3 post, 4 done
  logic [RAILS-1:0] m_rail;
  logic m_gpio, m_low, m_pg, m_nrst;
  int ph, slot, wl, c;
  string tag = "R1";

  function automatic int ms_of(input logic [1:0] code);
    return (code == 2'd3) ? 4 : (code == 2'd2) ? 1 : 0;
  endfunction

  function automatic int rel_ms(input logic [3:0] code);
    return ((code > 10 ? 10 : int'(code)) + 1) * 10;
  endfunction

  function automatic int slot_wait(input int s);
    if (s < SLOTS) return ms_of(cfg_dly[s*2 +: 2]) * DIV;
    return ms_of(cfg_x7) * DIV;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rail = '0; m_gpio = 0; m_low = 0; m_pg = 0; m_nrst = 0;
      ph = 0; slot = 0; wl = 0; c = 0; tag = "R1";
    end else begin
      m_gpio = 0;
      if (off_req) begin
        m_rail = '0; m_low = 0; m_pg = 0; m_nrst = 0; ph = 0; tag = "R9";
      end else if (ph == 0) begin
        if (pwr_req) begin m_rail[0] = 1'b1; ph = 1; wl = 5 * DIV; tag = "R3"; end
      end else if (ph == 1) begin
        if (wl == 0) begin ph = 2; slot = 0; wl = slot_wait(0); tag = "R4"; end
        else wl--;
      end else if (ph == 2) begin
        if (wl == 0) begin
          if (slot < SLOTS) begin
            if (cfg_dly[slot*2 +: 2] != 2'd0) begin
              if (cfg_rail[slot*3 +: 3] == 3'd0) m_gpio = 1'b1;
              else if (cfg_rail[slot*3 +: 3] != 3'd7) m_rail[cfg_rail[slot*3 +: 3]] = 1'b1;
            end
          end else if (cfg_x7 != 2'd0) begin
            m_rail[RAILS-1] = 1'b1; m_low = 1'b1;
          end
          slot++;
          if (slot > SLOTS) begin ph = 3; c = 0; tag = "R7"; end
          else wl = slot_wait(slot);
        end else wl--;
      end else if (ph == 3) begin
        if (c == 3 * DIV) m_pg = 1'b1;
        if (c == rel_ms(cfg_code) * DIV) begin m_nrst = 1'b1; ph = 4; tag = "R8"; end
        c++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  int gpio_cnt = 0;
  int t_pg = -1, t_rst = -1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tag, 32'(rail_en), 32'(m_rail));
      chk("R5", 32'(gpio_stb), 32'(m_gpio));
      chk("R6", 32'(lowv), 32'(m_low));
      chk(tag, 32'(pg), 32'(m_pg));
      chk(tag, 32'(nrst), 32'(m_nrst));
      if (gpio_stb) gpio_cnt++;
      if (pg && t_pg < 0) t_pg = cyc;
      if (nrst && t_rst < 0) t_rst = cyc;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIM && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIM);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pulse_req(input bit off);
    @(negedge clk);
    if (off) off_req = 1'b1; else pwr_req = 1'b1;
    @(negedge clk);
    off_req = 1'b0; pwr_req = 1'b0;
  endtask

  task automatic wait_done();
    while (ph != 4) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [RAILS-1:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {rail_en, gpio_stb, lowv, pg, nrst}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {rail_en, pg, nrst}, '0);

    // config A: rails 1,2,gpio,3(unused),7(ignored),4 ; mixed delays
    cfg_rail = {3'd4, 3'd7, 3'd3, 3'd0, 3'd2, 3'd1};
    cfg_dly  = {2'd3, 2'd1, 2'd0, 2'd3, 2'd1, 2'd2};
    cfg_x7   = 2'd2;
    cfg_code = 4'd0;
    @(negedge clk); pwr_req = 1'b1;
    @(negedge clk); pwr_req = 1'b0;
    // R2 primary rail alone, one cycle after the request
    chk("R2", {rail_en, pg, nrst, gpio_stb}, {8'h01, 3'b000});
    repeat (10) @(negedge clk);
    snap = rail_en;
    pulse_req(0);
    // R10 a request outside idle changes nothing
    chk("R10", 32'(rail_en), 32'(snap));
    wait_done();
    chk("R5", 32'(rail_en), 32'h97);
    chk("R5", 32'(gpio_cnt), 32'd1);
    chk("R6", 32'(lowv), 32'd1);
    chk("R8", 32'(t_rst - t_pg), 32'((10 - 3) * DIV));

    // R9 shutdown clears everything
    pulse_req(1);
    chk("R9", {rail_en, gpio_stb, lowv, pg, nrst}, '0);

    // config B: all 0 ms, rail 7 field ignored, seventh slot unused, code clamps
    cfg_rail = {3'd3, 3'd2, 3'd1, 3'd7, 3'd5, 3'd6};
    cfg_dly  = {2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1};
    cfg_x7   = 2'd0;
    cfg_code = 4'd15;
    pulse_req(0);
    repeat (5 * DIV + 3) @(negedge clk);
    // R9 shutdown in the middle of the slot walk
    @(negedge clk); off_req = 1'b1; pwr_req = 1'b1;
    @(negedge clk); off_req = 1'b0; pwr_req = 1'b0;
    chk("R9", {rail_en, pg, nrst}, '0);
    repeat (3) @(negedge clk);
    chk("R9", 32'(rail_en), 32'd0);
    t_pg = -1; t_rst = -1; gpio_cnt = 0;
    pulse_req(0);
    wait_done();
    chk("R5", 32'(rail_en), 32'h6F);
    chk("R6", 32'(lowv), 32'd0);
    chk("R5", 32'(gpio_cnt), 32'd0);
    chk("R8", 32'(t_rst - t_pg), 32'((110 - 3) * DIV));
    chk("R7", 32'(pg), 32'd1);
    pulse_req(1);
    chk("R9", {rail_en, pg, nrst}, '0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule